// File: doc/BRIEF.md
# Temperature Sensor Power Sequencer

This block drives the three control pins of an on-chip analog temperature sensor core: power-down, active-low reset and run. On an enable command it steps the core through a timed power-up order. It first holds power-down high for a short settle period. It then releases power-down while keeping reset asserted long enough for the analog core to come up. Finally it releases reset and waits a setup interval before the sensor counts as ready. All intervals are given in microseconds and turned into cycle counts from a clock-frequency parameter.

Once the sensor is ready, a read request starts one conversion. The block raises run together with reset-released for a short pulse and then waits for the sensor's done pulse. It reports the result as a one-cycle valid pulse with the sampled code latched beside it. If the done pulse never comes inside the timeout window, it reports a timeout pulse instead. A read while the sensor is off returns a not-enabled error without touching the pins. A disable command given during power-up or a conversion is held back until the sequencer is idle again.

Top module: `tsense_seq`

## Requirements
- R1: While reset is high and after its release, pd_o=1, rstn_o=0, run_o=0, and enabled_o, busy_o, valid_o, timeout_o and noen_err_o are all 0.
- R2: An en_cmd pulse while off keeps pd_o high for PRE_US*CLK_MHZ cycles. The block then drives pd_o=0 with rstn_o=0 for PU_US*CLK_MHZ cycles, then rstn_o=1 for SU_US*CLK_MHZ cycles before enabled_o rises.
- R3: A rd_req pulse while ready drives run_o=1, with rstn_o=1 and pd_o=0, for RUN_US*CLK_MHZ cycles. run_o then returns to 0. run_o is never 1 unless rstn_o=1 and pd_o=0.
- R4: A done_i pulse seen while waiting gives exactly one valid_o pulse. In that pulse code_o equals code_i as sampled with done_i, and the block returns to ready.
- R5: If no done_i comes within TO_US*CLK_MHZ cycles after run_o falls, timeout_o pulses for one cycle and the block returns to ready. A done_i on the last cycle of that window still counts as a valid result. A done_i outside the window produces nothing. At most one of valid_o, timeout_o and noen_err_o is high in any cycle.
- R6: A rd_req while off gives a noen_err_o pulse on the next cycle, and pd_o, rstn_o and run_o keep their off values.
- R7: A dis_cmd while ready drives pd_o=1 and rstn_o=0 and clears enabled_o on the next cycle.
- R8: en_cmd while enabled, and dis_cmd while off, leave the pins and status outputs unchanged.
- R9: A rd_req while busy is ignored. It starts no second run pulse and produces no second result.
- R10: A dis_cmd during a conversion is deferred. The pins stay powered until the result is reported, and the sensor powers down on the cycle after that.
- R11: When rd_req and dis_cmd arrive together while ready, the disable takes effect and the read is answered with noen_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_cmd | input | 1 | Enable command pulse |
| dis_cmd | input | 1 | Disable command pulse |
| rd_req | input | 1 | Conversion request pulse |
| done_i | input | 1 | Conversion-done pulse from the sensor |
| code_i | input | CODE_W | Sensor output code |
| pd_o | output | 1 | Sensor power-down, 1 = powered down |
| rstn_o | output | 1 | Sensor reset, 0 = held in reset |
| run_o | output | 1 | Sensor conversion start |
| enabled_o | output | 1 | Sensor powered and ready or converting |
| busy_o | output | 1 | Power-up or conversion in progress |
| valid_o | output | 1 | One-cycle result pulse |
| code_o | output | CODE_W | Latched sensor code |
| timeout_o | output | 1 | One-cycle conversion timeout pulse |
| noen_err_o | output | 1 | One-cycle not-enabled error pulse |

## Verification
The done pulse and the expiry of the timeout window can land on the same clock edge. The stub sensor is told to answer exactly on the last cycle of the window, and a correct design must report valid with the stub's code and no timeout. The stub then answers one cycle later, and the bench expects a timeout followed by silence, since the late done falls outside the window. The scoreboard judges both cases, because any unexpected or wrong-kind result pulse fails the comparison.

// File: rtl/tsense_pkg.sv
package tsense_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_PRE,
    ST_PWRUP,
    ST_SETUP,
    ST_READY,
    ST_RUN,
    ST_WAIT
  } seq_state_e;

  typedef struct packed {
    logic pd;
    logic rstn;
    logic run;
  } pins_t;

  function automatic pins_t pins_for(seq_state_e s);
    pins_t p;
    case (s)
      ST_OFF:   p = '{pd: 1'b1, rstn: 1'b0, run: 1'b0};
      ST_PRE:   p = '{pd: 1'b1, rstn: 1'b0, run: 1'b0};
      ST_PWRUP: p = '{pd: 1'b0, rstn: 1'b0, run: 1'b0};
      ST_SETUP: p = '{pd: 1'b0, rstn: 1'b1, run: 1'b0};
      ST_READY: p = '{pd: 1'b0, rstn: 1'b1, run: 1'b0};
      ST_RUN:   p = '{pd: 1'b0, rstn: 1'b1, run: 1'b1};
      ST_WAIT:  p = '{pd: 1'b0, rstn: 1'b1, run: 1'b0};
      default:  p = '{pd: 1'b1, rstn: 1'b0, run: 1'b0};
    endcase
    return p;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tsense_timer.sv
module tsense_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);

  // R5: an expired interval stays expired until reloaded
  assert_cnt_stops_R5: assert property (@(posedge clk) disable iff (rst)
    (!load && zero) |=> zero);

endmodule

// File: rtl/tsense_capture.sv
module tsense_capture #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take,
  input  logic [W-1:0] code_in,
  output logic [W-1:0] code_q
);
  always_ff @(posedge clk) begin
    if (rst)       code_q <= '0;
    else if (take) code_q <= code_in;
  end

  // R4: the latched code only moves on a capture
  assert_code_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(take) |-> $stable(code_q));

endmodule

// File: rtl/tsense_seq.sv
module tsense_seq
  import tsense_pkg::*;
#(
  parameter int CLK_MHZ = 100,
  parameter int PRE_US  = 1,
  parameter int PU_US   = 60,
  parameter int SU_US   = 1,
  parameter int RUN_US  = 1,
  parameter int TO_US   = 10000,
  parameter int CODE_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_cmd,
  input  logic              dis_cmd,
  input  logic              rd_req,
  input  logic              done_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              pd_o,
  output logic              rstn_o,
  output logic              run_o,
  output logic              enabled_o,
  output logic              busy_o,
  output logic              valid_o,
  output logic [CODE_W-1:0] code_o,
  output logic              timeout_o,
  output logic              noen_err_o
);
  localparam int PRE_CYC = PRE_US * CLK_MHZ;
  localparam int PU_CYC  = PU_US  * CLK_MHZ;
  localparam int SU_CYC  = SU_US  * CLK_MHZ;
  localparam int RUN_CYC = RUN_US * CLK_MHZ;
  localparam int TO_CYC  = TO_US  * CLK_MHZ;
  localparam int MAX_CYC = imax(imax(imax(PRE_CYC, PU_CYC), imax(SU_CYC, RUN_CYC)), TO_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seq_state_e       state, nxt;
  logic             dis_pend, dis_pend_n;
  logic             take, to_hit, noen;
  logic             load, zero;
  logic [CNT_W-1:0] load_val;
  pins_t            pn;

  // next-state and command handling
  always_comb begin
    nxt        = state;
    dis_pend_n = dis_pend;
    take       = 1'b0;
    to_hit     = 1'b0;
    noen       = 1'b0;
    case (state)
      ST_OFF: begin
        if (rd_req) noen = 1'b1;
        if (en_cmd && !dis_cmd) nxt = ST_PRE;
      end
      ST_PRE:   if (zero) nxt = ST_PWRUP;
      ST_PWRUP: if (zero) nxt = ST_SETUP;
      ST_SETUP: if (zero) nxt = ST_READY;
      ST_READY: begin
        if (dis_cmd || dis_pend) begin
          nxt = ST_OFF;
          if (rd_req) noen = 1'b1;
        end else if (rd_req) begin
          nxt = ST_RUN;
        end
      end
      ST_RUN:   if (zero) nxt = ST_WAIT;
      ST_WAIT: begin
        if (done_i) begin
          take = 1'b1;
          nxt  = ST_READY;
        end else if (zero) begin
          to_hit = 1'b1;
          nxt    = ST_READY;
        end
      end
      default: nxt = ST_OFF;
    endcase
    if (state inside {ST_PRE, ST_PWRUP, ST_SETUP, ST_RUN, ST_WAIT}) begin
      if (dis_cmd)     dis_pend_n = 1'b1;
      else if (en_cmd) dis_pend_n = 1'b0;
    end
    if (nxt == ST_OFF) dis_pend_n = 1'b0;
  end

  // interval length for the state being entered
  always_comb begin
    load = (nxt != state);
    case (nxt)
      ST_PRE:   load_val = CNT_W'(PRE_CYC - 1);
      ST_PWRUP: load_val = CNT_W'(PU_CYC - 1);
      ST_SETUP: load_val = CNT_W'(SU_CYC - 1);
      ST_RUN:   load_val = CNT_W'(RUN_CYC - 1);
      ST_WAIT:  load_val = CNT_W'(TO_CYC - 1);
      default:  load_val = '0;
    endcase
  end

  tsense_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .zero     (zero)
  );

  tsense_capture #(.W(CODE_W)) u_capture (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .code_in (code_i),
    .code_q  (code_o)
  );

  assign pn = pins_for(nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_OFF;
      dis_pend   <= 1'b0;
      pd_o       <= 1'b1;
      rstn_o     <= 1'b0;
      run_o      <= 1'b0;
      enabled_o  <= 1'b0;
      busy_o     <= 1'b0;
      valid_o    <= 1'b0;
      timeout_o  <= 1'b0;
      noen_err_o <= 1'b0;
    end else begin
      state      <= nxt;
      dis_pend   <= dis_pend_n;
      pd_o       <= pn.pd;
      rstn_o     <= pn.rstn;
      run_o      <= pn.run;
      enabled_o  <= (nxt inside {ST_READY, ST_RUN, ST_WAIT});
      busy_o     <= (nxt inside {ST_PRE, ST_PWRUP, ST_SETUP, ST_RUN, ST_WAIT});
      valid_o    <= take;
      timeout_o  <= to_hit;
      noen_err_o <= noen;
    end
  end

  // R3: run only on a powered, released core
  assert_run_gated_R3: assert property (@(posedge clk) disable iff (rst)
    run_o |-> (rstn_o && !pd_o));
  // R5: result pulses are mutually exclusive
  assert_one_flag_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({valid_o, timeout_o, noen_err_o}));
  // R4: valid lasts a single cycle
  assert_valid_single_R4: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  // R6: not-enabled errors only come with the core powered down
  assert_noen_off_R6: assert property (@(posedge clk) disable iff (rst)
    noen_err_o |-> (pd_o && !enabled_o));
  // R2: reset is released only after power-down was already low
  assert_reset_release_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(rstn_o) |-> $past(!pd_o));
  // R7: enabled implies powered and out of reset
  assert_ready_pins_R7: assert property (@(posedge clk) disable iff (rst)
    enabled_o |-> (!pd_o && rstn_o));

endmodule

// File: tb/tsense_seq_bench.sv
module tsense_seq_bench;
  localparam int CLK_MHZ = 1;
  localparam int PRE_US  = 1;
  localparam int PU_US   = 60;
  localparam int SU_US   = 1;
  localparam int RUN_US  = 1;
  localparam int TO_US   = 200;
  localparam int CODE_W  = 12;
  localparam int PRE_CYC = PRE_US * CLK_MHZ;
  localparam int PU_CYC  = PU_US * CLK_MHZ;
  localparam int SU_CYC  = SU_US * CLK_MHZ;
  localparam int RUN_CYC = RUN_US * CLK_MHZ;
  localparam int TO_CYC  = TO_US * CLK_MHZ;
  localparam int K_VALID = 1, K_TIMEOUT = 2, K_NOEN = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_cmd = 1'b0, dis_cmd = 1'b0, rd_req = 1'b0, done_i = 1'b0;
  logic [CODE_W-1:0] code_i = '0;
  logic pd_o, rstn_o, run_o, enabled_o, busy_o, valid_o, timeout_o, noen_err_o;
  logic [CODE_W-1:0] code_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int    exp_kind_q[$];
  int    exp_code_q[$];
  string exp_tag_q[$];

  bit                stub_on = 1'b1;
  int                stub_delay = 0;
  logic [CODE_W-1:0] stub_code = '0;

  always #2.5 clk = ~clk;

  tsense_seq #(
    .CLK_MHZ(CLK_MHZ), .PRE_US(PRE_US), .PU_US(PU_US), .SU_US(SU_US),
    .RUN_US(RUN_US), .TO_US(TO_US), .CODE_W(CODE_W)
  ) u_tsense_seq (
    .clk(clk), .rst(rst), .en_cmd(en_cmd), .dis_cmd(dis_cmd), .rd_req(rd_req),
    .done_i(done_i), .code_i(code_i), .pd_o(pd_o), .rstn_o(rstn_o), .run_o(run_o),
    .enabled_o(enabled_o), .busy_o(busy_o), .valid_o(valid_o), .code_o(code_o),
    .timeout_o(timeout_o), .noen_err_o(noen_err_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic expect_item(input int kind, input int code, input string tag);
    exp_kind_q.push_back(kind);
    exp_code_q.push_back(code);
    exp_tag_q.push_back(tag);
  endtask

  // behavioural sensor: answers stub_delay cycles after run falls
  initial begin
    logic prev_run;
    prev_run = 1'b0;
    forever begin
      @(negedge clk);
      if (prev_run && !run_o && stub_on) begin
        repeat (stub_delay) @(negedge clk);
        code_i = stub_code;
        done_i = 1'b1;
        @(negedge clk);
        done_i = 1'b0;
        code_i = '0;
      end
      prev_run = run_o;
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && (valid_o || timeout_o || noen_err_o)) begin
        int akind, acode;
        akind = valid_o ? K_VALID : (timeout_o ? K_TIMEOUT : K_NOEN);
        acode = valid_o ? int'(code_o) : 0;
        if (exp_kind_q.size() == 0) begin
          chk(1'b0, "unexpected result", akind, 0);
        end else begin
          int ek, ec;
          string et;
          ek = exp_kind_q.pop_front();
          ec = exp_code_q.pop_front();
          et = exp_tag_q.pop_front();
          chk(ek == akind, et, akind, ek);
          chk(ec == acode, et, acode, ec);
        end
      end
    end
  end

  task automatic pulse_en();
    @(negedge clk); en_cmd = 1'b1;
    @(negedge clk); en_cmd = 1'b0;
  endtask

  task automatic pulse_dis();
    @(negedge clk); dis_cmd = 1'b1;
    @(negedge clk); dis_cmd = 1'b0;
  endtask

  task automatic do_enable();
    int n;
    pulse_en();
    n = 0;
    while (pd_o) begin n++; @(negedge clk); end
    chk(n == PRE_CYC, "R2 pre-settle cycles", n, PRE_CYC);
    n = 0;
    while (!pd_o && !rstn_o) begin n++; @(negedge clk); end
    chk(n == PU_CYC, "R2 power-up hold cycles", n, PU_CYC);
    n = 0;
    while (rstn_o && !enabled_o) begin n++; @(negedge clk); end
    chk(n == SU_CYC, "R2 setup cycles", n, SU_CYC);
    chk(enabled_o && !busy_o && !pd_o && rstn_o, "R2 ready state",
        {enabled_o, busy_o, pd_o, rstn_o}, 4'b1001);
  endtask

  task automatic do_read();
    int n;
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    n = 0;
    while (run_o) begin
      chk(rstn_o && !pd_o, "R3 pins during run", {rstn_o, pd_o}, 2'b10);
      n++;
      @(negedge clk);
    end
    chk(n == RUN_CYC, "R3 run pulse cycles", n, RUN_CYC);
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(pd_o && !rstn_o && !run_o, "R1 pins in reset", {pd_o, rstn_o, run_o}, 3'b100);
    rst = 1'b0;
    @(negedge clk);
    chk(pd_o && !rstn_o && !run_o && !enabled_o && !busy_o &&
        !valid_o && !timeout_o && !noen_err_o, "R1 state after reset",
        {pd_o, rstn_o, run_o, enabled_o, busy_o}, 5'b10000);

    // R8: disable while off
    pulse_dis();
    repeat (3) begin
      chk(pd_o && !rstn_o && !busy_o, "R8 disable while off", {pd_o, rstn_o, busy_o}, 3'b100);
      @(negedge clk);
    end

    // R6: read while off
    expect_item(K_NOEN, 0, "R6 read while off");
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    chk(noen_err_o && pd_o && !rstn_o && !run_o, "R6 pins untouched",
        {noen_err_o, pd_o, rstn_o, run_o}, 4'b1100);

    do_enable();

    // R8: enable while enabled
    pulse_en();
    repeat (3) begin
      chk(enabled_o && !busy_o && !pd_o && rstn_o, "R8 enable while enabled",
          {enabled_o, busy_o, pd_o, rstn_o}, 4'b1001);
      @(negedge clk);
    end

    // R4: plain conversions
    stub_on = 1'b1; stub_delay = 3; stub_code = 12'hABC;
    expect_item(K_VALID, 12'hABC, "R4 result delay 3");
    do_read();
    wait_idle();
    @(negedge clk);
    chk(code_o == 12'hABC && enabled_o, "R4 code held and ready", code_o, 12'hABC);

    stub_delay = 0; stub_code = 12'h123;
    expect_item(K_VALID, 12'h123, "R4 result delay 0");
    do_read();
    wait_idle();

    // R5: done on the final window cycle
    stub_delay = TO_CYC - 1; stub_code = 12'h7FF;
    expect_item(K_VALID, 12'h7FF, "R5 done on last window cycle");
    do_read();
    wait_idle();
    repeat (3) @(negedge clk);

    // R5: done one cycle late gives timeout, late done ignored
    stub_delay = TO_CYC; stub_code = 12'h0AA;
    expect_item(K_TIMEOUT, 0, "R5 done one cycle late");
    do_read();
    wait_idle();
    repeat (5) @(negedge clk);
    chk(code_o == 12'h7FF, "R5 late done not captured", code_o, 12'h7FF);

    // R5: no reply at all
    stub_on = 1'b0;
    expect_item(K_TIMEOUT, 0, "R5 no reply");
    do_read();
    wait_idle();
    @(negedge clk);
    chk(enabled_o && !busy_o, "R5 ready after timeout", {enabled_o, busy_o}, 2'b10);
    stub_on = 1'b1;

    // R9: read while busy ignored
    stub_delay = 10; stub_code = 12'h555;
    expect_item(K_VALID, 12'h555, "R9 single result");
    do_read();
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    wait_idle();
    repeat (5) begin
      chk(!run_o, "R9 no second run", run_o, 0);
      @(negedge clk);
    end

    // R10: disable during conversion deferred
    stub_delay = 10; stub_code = 12'h0F0;
    expect_item(K_VALID, 12'h0F0, "R10 result before power-down");
    do_read();
    pulse_dis();
    chk(!pd_o && enabled_o, "R10 still powered after disable", {pd_o, enabled_o}, 2'b01);
    wait_idle();
    @(negedge clk);
    chk(pd_o && !rstn_o && !enabled_o, "R10 powered down after result",
        {pd_o, rstn_o, enabled_o}, 3'b100);

    // R7: disable while ready
    do_enable();
    pulse_dis();
    chk(pd_o && !rstn_o && !enabled_o, "R7 disable while ready",
        {pd_o, rstn_o, enabled_o}, 3'b100);

    // R11: read and disable together
    do_enable();
    expect_item(K_NOEN, 0, "R11 read with disable");
    @(negedge clk); rd_req = 1'b1; dis_cmd = 1'b1;
    @(negedge clk); rd_req = 1'b0; dis_cmd = 1'b0;
    chk(pd_o && !rstn_o && !run_o, "R11 disable wins", {pd_o, rstn_o, run_o}, 3'b100);

    repeat (10) @(negedge clk);
    chk(exp_kind_q.size() == 0, "scoreboard drained", exp_kind_q.size(), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule